// File: doc/BRIEF.md
# Dual-Side Offset and Gain Calibrator

This block corrects a stream of converter samples on two input channels. Each channel is sampled through two integrators that take turns, side A and side B. The two sides differ slightly in offset and gain. Each incoming sample carries a channel tag and a side tag. The block picks the coefficient pair stored for that channel and side, subtracts the offset from the raw value and then scales the difference by the gain. With all four pairs tuned, the alternating A/B data of one channel can be treated as a single continuous channel.

The coefficients live in a small register file. A host can write them, and two automatic procedures can also set them. The auto-offset procedure averages a fixed number of samples per channel and side while the inputs are held at zero. It loads those averages as offsets and then switches calibration on. The auto-gain procedure averages offset-corrected samples under a full-scale input. It then uses a sequential divider to set each B-side gain so that the corrected B mean matches the corrected A mean. A single enable bit bypasses the correction without disturbing the stored coefficients.

Top module: `sidecal_top`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are 0 and calibration is off. Every offset resets to 0 and every gain to 1.0 (0x10000), so with calibration on, each output equals its raw input.
- R2: With calibration on, a sample accepted on `in_valid` appears on `out_data` two clock edges later, with `out_valid` high. Its value is floor((raw − offset) × gain / 2^16) as a signed 24-bit number, clipped to the 24-bit signed range. The gain is an unsigned Q2.16 value.
- R3: The coefficient pair is chosen by slot index {`in_chan`, `in_side`}. `in_side` 0 selects side A and 1 selects side B. `in_chan` 0 selects channel 1 and 1 selects channel 2.
- R4: A host write with `cfg_addr[3]`=0 targets the slot given by `cfg_addr[1:0]` (channel in bit 1, side in bit 0). `cfg_addr[2]`=0 writes the 20-bit offset and `cfg_addr[2]`=1 writes the gain from `cfg_wdata[17:0]`. With `cfg_addr[3]`=1, the write sets the calibration enable from `cfg_wdata[0]`.
- R5: With calibration off, `out_data` is the raw sample zero-extended, using the same two-edge latency. Turning calibration off and back on keeps the stored coefficients.
- R6: A `start_off` pulse in idle begins auto-offset. For each slot, the first N = 2^k accepted samples are summed, where k is `avg_log2` clamped to the range 4 to 10. Samples beyond N for a slot are ignored. When all four slots have N samples, each offset becomes the floor of its sum / N and calibration is turned on.
- R7: A `start_gain` pulse in idle begins auto-gain, using the same count N. For each slot it sums the first N values of (raw − offset). For each channel with positive A and B sums, the B gain becomes floor(gainA × sumA / sumB), capped at 0x3FFFF. This value is written only when the divider signals completion. A-side gains and all offsets are left unchanged.
- R8: `busy` is high from the edge after a start pulse until the procedure ends, and host writes are ignored while `busy` is high. `done` pulses high for exactly one cycle as `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sample present |
| in_data | input | 20 | Raw unsigned sample |
| in_chan | input | 1 | Channel tag (0 = channel 1, 1 = channel 2) |
| in_side | input | 1 | Integrator side tag (0 = A, 1 = B) |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | 24 | Corrected signed sample |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 4 | Host write address |
| cfg_wdata | input | 20 | Host write data |
| avg_log2 | input | 4 | log2 of the per-slot averaging count |
| start_off | input | 1 | Start auto-offset |
| start_gain | input | 1 | Start auto-gain |
| busy | output | 1 | Automatic procedure running |
| done | output | 1 | One-cycle pulse at procedure end |

## Verification
The bench drives a sample just after a falling edge and drops `in_valid` at the next falling edge. It reads `out_valid` and `out_data` at the third falling edge, after the stage-one and output registers have both loaded. A host write takes effect at the rising edge between its two falling edges, so the next sample already sees the new coefficient. Auto-offset finishes one edge after the last needed sample is counted. Auto-gain then adds about 50 cycles of division per channel. Because this delay is not fixed, the bench polls `done` at falling edges within a bounded window and only then probes the new coefficients through the sample path.

// File: rtl/sidecal_pkg.sv
package sidecal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFF,
    ST_GAIN,
    ST_PREP,
    ST_DIV
  } cal_state_t;

  function automatic logic [1:0] slot_of(input logic chan, input logic side);
    return {chan, side};
  endfunction

endpackage

// File: rtl/sidecal_coef.sv
module sidecal_coef #(
  parameter int RAW_W  = 20,
  parameter int GAIN_W = 18,
  parameter int FRAC   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_we,
  input  logic                        host_is_gain,
  input  logic [1:0]                  host_slot,
  input  logic [RAW_W-1:0]            host_data,
  input  logic                        off_load,
  input  logic [3:0][RAW_W-1:0]       off_vals,
  input  logic                        gb_we,
  input  logic                        gb_chan,
  input  logic [GAIN_W-1:0]           gb_val,
  output logic [3:0][RAW_W-1:0]       off_q,
  output logic [3:0][GAIN_W-1:0]      gain_q
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC;

  for (genvar i = 0; i < 4; i++) begin : g_slot
    localparam logic [1:0] SLOT = 2'(i);
    localparam bit IS_B = (i % 2) == 1;
    localparam bit CHAN = (i / 2) == 1;
    logic host_hit;
    logic auto_b_hit;
    assign host_hit   = host_we && (host_slot == SLOT);
    assign auto_b_hit = IS_B && gb_we && (gb_chan == CHAN);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_q[i]  <= '0;
        gain_q[i] <= UNITY;
      end else begin
        if (off_load)
          off_q[i] <= off_vals[i];
        else if (host_hit && !host_is_gain)
          off_q[i] <= host_data;
        if (auto_b_hit)
          gain_q[i] <= gb_val;
        else if (host_hit && host_is_gain)
          gain_q[i] <= host_data[GAIN_W-1:0];
      end
    end
  end

endmodule

// File: rtl/sidecal_dp.sv
module sidecal_dp #(
  parameter int RAW_W  = 20,
  parameter int GAIN_W = 18,
  parameter int FRAC   = 16,
  parameter int OUT_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [RAW_W-1:0]        in_data,
  input  logic                    en,
  input  logic [RAW_W-1:0]        off,
  input  logic [GAIN_W-1:0]       gain,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data
);
  localparam int PW = RAW_W + GAIN_W + 2;
  localparam logic signed [PW-1:0] OMAX = PW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] OMIN = -OMAX - PW'(1);

  function automatic logic signed [RAW_W:0] sub_off(input logic [RAW_W-1:0] raw,
                                                    input logic [RAW_W-1:0] o);
    return $signed({1'b0, raw}) - $signed({1'b0, o});
  endfunction

  function automatic logic [OUT_W-1:0] scale_sat(input logic signed [RAW_W:0] d,
                                                 input logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] sh;
    prod = PW'(d) * PW'($signed({1'b0, g}));
    sh   = prod >>> FRAC;
    if (sh > OMAX)      return OMAX[OUT_W-1:0];
    else if (sh < OMIN) return OMIN[OUT_W-1:0];
    else                return sh[OUT_W-1:0];
  endfunction

  logic                     s1_valid;
  logic                     s1_en;
  logic [RAW_W-1:0]         s1_raw;
  logic signed [RAW_W:0]    s1_diff;
  logic [GAIN_W-1:0]        s1_gain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_en     <= 1'b0;
      s1_raw    <= '0;
      s1_diff   <= '0;
      s1_gain   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_en   <= en;
        s1_raw  <= in_data;
        s1_diff <= sub_off(in_data, off);
        s1_gain <= gain;
      end
      out_valid <= s1_valid;
      if (s1_valid)
        out_data <= s1_en ? scale_sat(s1_diff, s1_gain) : OUT_W'(s1_raw);
    end
  end

endmodule

// File: rtl/sidecal_acc.sv
module sidecal_acc #(
  parameter int RAW_W = 20,
  parameter int CNT_W = 11,
  parameter int ACC_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     take,
  input  logic [1:0]               slot,
  input  logic signed [RAW_W:0]    value,
  input  logic [CNT_W-1:0]         limit,
  output logic [3:0][ACC_W-1:0]    sums,
  output logic                     all_full
);
  logic [3:0] full;

  for (genvar i = 0; i < 4; i++) begin : g_slot
    localparam logic [1:0] SLOT = 2'(i);
    logic [CNT_W-1:0] cnt;
    assign full[i] = (cnt >= limit);

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        sums[i] <= '0;
        cnt     <= '0;
      end else if (take && (slot == SLOT) && !full[i]) begin
        sums[i] <= sums[i] + ACC_W'(value);
        cnt     <= cnt + CNT_W'(1);
      end
    end
  end

  assign all_full = &full;

endmodule

// File: rtl/sidecal_div.sv
module sidecal_div #(
  parameter int NW = 49,
  parameter int DW = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NW-1:0]   num,
  input  logic [DW-1:0]   den,
  output logic            done,
  output logic [NW-1:0]   quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem;
  logic [NW-1:0] n_sh;
  logic [CW-1:0] left;
  logic          run;
  logic [DW:0]   trial;

  assign trial = {rem, n_sh[NW-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      n_sh <= '0;
      quo  <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        rem  <= '0;
        n_sh <= num;
        quo  <= '0;
        left <= CW'(NW);
        run  <= 1'b1;
      end else if (run) begin
        n_sh <= n_sh << 1;
        if (trial >= {1'b0, den}) begin
          rem <= DW'(trial - {1'b0, den});
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= trial[DW-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
        left <= left - CW'(1);
        if (left == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sidecal_top.sv
module sidecal_top
  import sidecal_pkg::*;
#(
  parameter int RAW_W    = 20,
  parameter int GAIN_W   = 18,
  parameter int FRAC     = 16,
  parameter int OUT_W    = 24,
  parameter int LOG2_MIN = 4,
  parameter int LOG2_MAX = 10,
  localparam int LGW     = $clog2(LOG2_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [RAW_W-1:0]   in_data,
  input  logic               in_chan,
  input  logic               in_side,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [RAW_W-1:0]   cfg_wdata,
  input  logic [LGW-1:0]     avg_log2,
  input  logic               start_off,
  input  logic               start_gain,
  output logic               busy,
  output logic               done
);
  localparam int CNT_W = LOG2_MAX + 1;
  localparam int ACC_W = RAW_W + 2 + LOG2_MAX;
  localparam int DW    = ACC_W - 1;
  localparam int NW    = DW + GAIN_W;

  function automatic logic [LGW-1:0] clamp_lg(input logic [LGW-1:0] v);
    if (int'(v) < LOG2_MIN)      return LGW'(LOG2_MIN);
    else if (int'(v) > LOG2_MAX) return LGW'(LOG2_MAX);
    else                         return v;
  endfunction

  function automatic logic [GAIN_W-1:0] cap_gain(input logic [NW-1:0] q);
    return (|q[NW-1:GAIN_W]) ? '1 : q[GAIN_W-1:0];
  endfunction

  cal_state_t                 state;
  logic                       cal_en;
  logic                       ch;
  logic [LGW-1:0]             lg_q;
  logic [1:0]                 in_slot;
  logic [3:0][RAW_W-1:0]      off_q;
  logic [3:0][RAW_W-1:0]      off_vals;
  logic [3:0][GAIN_W-1:0]     gain_q;
  logic [3:0][ACC_W-1:0]      sums;
  logic                       acc_full;
  logic                       acc_clear;
  logic                       acc_take;
  logic signed [RAW_W:0]      acc_val;
  logic                       host_ok;
  logic                       off_load;
  logic                       gb_we;
  logic                       div_start;
  logic                       div_done;
  logic [NW-1:0]              div_quo;
  logic [ACC_W-1:0]           sum_a;
  logic [ACC_W-1:0]           sum_b;
  logic                       sums_pos;

  assign in_slot  = slot_of(in_chan, in_side);
  assign busy     = (state != ST_IDLE);
  assign host_ok  = cfg_we && !busy;

  assign acc_clear = (state == ST_IDLE) && (start_off || start_gain);
  assign acc_take  = in_valid && ((state == ST_OFF) || (state == ST_GAIN));
  assign acc_val   = (state == ST_GAIN)
                   ? ($signed({1'b0, in_data}) - $signed({1'b0, off_q[in_slot]}))
                   : $signed({1'b0, in_data});

  assign sum_a    = sums[slot_of(ch, 1'b0)];
  assign sum_b    = sums[slot_of(ch, 1'b1)];
  assign sums_pos = ($signed(sum_a) > 0) && ($signed(sum_b) > 0);

  assign off_load  = (state == ST_OFF) && acc_full;
  assign div_start = (state == ST_PREP) && sums_pos;
  assign gb_we     = (state == ST_DIV) && div_done;

  for (genvar i = 0; i < 4; i++) begin : g_avg
    assign off_vals[i] = RAW_W'($signed(sums[i]) >>> lg_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cal_en <= 1'b0;
      done   <= 1'b0;
      ch     <= 1'b0;
      lg_q   <= LGW'(LOG2_MIN);
    end else begin
      done <= 1'b0;
      if (host_ok && cfg_addr[3])
        cal_en <= cfg_wdata[0];
      unique case (state)
        ST_IDLE: begin
          if (start_off) begin
            lg_q  <= clamp_lg(avg_log2);
            state <= ST_OFF;
          end else if (start_gain) begin
            lg_q  <= clamp_lg(avg_log2);
            state <= ST_GAIN;
          end
        end
        ST_OFF: begin
          if (acc_full) begin
            cal_en <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_GAIN: begin
          if (acc_full) begin
            ch    <= 1'b0;
            state <= ST_PREP;
          end
        end
        ST_PREP: begin
          if (sums_pos) begin
            state <= ST_DIV;
          end else if (ch) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            ch <= 1'b1;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            if (ch) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              ch    <= 1'b1;
              state <= ST_PREP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  sidecal_coef #(.RAW_W(RAW_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_coef (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (host_ok && !cfg_addr[3]),
    .host_is_gain (cfg_addr[2]),
    .host_slot    (cfg_addr[1:0]),
    .host_data    (cfg_wdata),
    .off_load     (off_load),
    .off_vals     (off_vals),
    .gb_we        (gb_we),
    .gb_chan      (ch),
    .gb_val       (cap_gain(div_quo)),
    .off_q        (off_q),
    .gain_q       (gain_q)
  );

  sidecal_acc #(.RAW_W(RAW_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (acc_clear),
    .take     (acc_take),
    .slot     (in_slot),
    .value    (acc_val),
    .limit    (CNT_W'(1) << lg_q),
    .sums     (sums),
    .all_full (acc_full)
  );

  sidecal_div #(.NW(NW), .DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (NW'(sum_a[DW-1:0]) * NW'(gain_q[slot_of(ch, 1'b0)])),
    .den   (sum_b[DW-1:0]),
    .done  (div_done),
    .quo   (div_quo)
  );

  sidecal_dp #(.RAW_W(RAW_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .en        (cal_en),
    .off       (off_q[in_slot]),
    .gain      (gain_q[in_slot]),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/sidecal_chk.sv
module sidecal_chk #(
  parameter int RAW_W  = 20,
  parameter int GAIN_W = 18,
  parameter int OUT_W  = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [RAW_W-1:0]         in_data,
  input logic                     out_valid,
  input logic [OUT_W-1:0]         out_data,
  input logic                     cal_en,
  input logic                     busy,
  input logic                     done,
  input logic                     div_done,
  input logic                     off_load,
  input logic [3:0][RAW_W-1:0]    off_q,
  input logic [3:0][GAIN_W-1:0]   gain_q
);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  assert_bypass_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cal_en) |=> ##1 (out_data == OUT_W'($past(in_data, 2))));

  assert_auto_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    off_load |=> cal_en);

  assert_gain_after_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_done) |=> $stable(gain_q));

  assert_offset_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !off_load) |=> $stable(off_q));

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sidecal_top sidecal_chk #(.RAW_W(RAW_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .cal_en    (cal_en),
  .busy      (busy),
  .done      (done),
  .div_done  (div_done),
  .off_load  (off_load),
  .off_q     (off_q),
  .gain_q    (gain_q)
);

// File: tb/sidecal_top_tb.sv
module sidecal_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] in_data = '0;
  logic        in_chan = 1'b0;
  logic        in_side = 1'b0;
  logic        out_valid;
  logic [23:0] out_data;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic [3:0]  avg_log2 = 4'd4;
  logic        start_off = 1'b0;
  logic        start_gain = 1'b0;
  logic        busy;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;

  longint m_off [4];
  longint m_gain[4];
  bit     m_en;

  always #10 clk = ~clk;

  sidecal_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_chan(in_chan), .in_side(in_side), .out_valid(out_valid), .out_data(out_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .avg_log2(avg_log2),
    .start_off(start_off), .start_gain(start_gain), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_out(input longint raw, input int slot);
    longint p;
    if (!m_en) return raw;
    p = (raw - m_off[slot]) * m_gain[slot];
    p = p >>> 16;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  task automatic cfg_wr(input logic [3:0] a, input longint d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d[19:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coef(input int slot, input bit is_gain, input longint v);
    cfg_wr({1'b0, is_gain, 2'(slot)}, v);
    if (is_gain) m_gain[slot] = v; else m_off[slot] = v;
  endtask

  task automatic set_en(input bit e);
    cfg_wr(4'b1000, longint'(e));
    m_en = e;
  endtask

  task automatic sample(input longint raw, input int slot, output longint val, output bit vld);
    @(negedge clk);
    in_valid = 1'b1; in_data = raw[19:0]; in_chan = slot[1]; in_side = slot[0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    vld = out_valid;
    val = longint'($signed(out_data));
  endtask

  task automatic probe(input string req, input longint raw, input int slot);
    longint v; bit vl;
    sample(raw, slot, v, vl);
    chk(req, v, model_out(raw, slot));
  endtask

  task automatic feed(input longint raw, input int slot);
    @(negedge clk);
    in_valid = 1'b1; in_data = raw[19:0]; in_chan = slot[1]; in_side = slot[0];
  endtask

  task automatic feed_end();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input int max_cyc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < max_cyc && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  // R1: reset state and unity coefficients
  task automatic t_reset();
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    chk("R1 out_valid", longint'(out_valid), 0);
    set_en(1'b1);
    for (int s = 0; s < 4; s++) probe("R1 unity", 12345 * (s + 1), s);
  endtask

  // R2 R3 R4: formula, slot selection, address map
  task automatic t_formula();
    longint v; bit vl;
    set_coef(0, 0, 1000);  set_coef(0, 1, 'h10000);
    set_coef(1, 0, 2500);  set_coef(1, 1, 'h11000);
    set_coef(2, 0, 40);    set_coef(2, 1, 'h0C000);
    set_coef(3, 0, 1000);  set_coef(3, 1, 'h18001);
    sample(500000, 0, v, vl);
    chk("R2 out_valid", longint'(vl), 1);
    chk("R2 value slot0", v, model_out(500000, 0));
    for (int s = 1; s < 4; s++) probe("R3 slot select", 300000, s);
    probe("R2 negative floor", 10, 3);
    probe("R4 max raw", 1048575, 1);
    probe("R2 low raw", 41, 2);
  endtask

  // R5: bypass keeps coefficients
  task automatic t_bypass();
    set_en(1'b0);
    probe("R5 bypass slot1", 777777, 1);
    probe("R5 bypass slot3", 5, 3);
    set_en(1'b1);
    probe("R5 coefficients kept", 300000, 1);
    probe("R5 coefficients kept neg", 10, 3);
  endtask

  // R6 R8: auto-offset
  task automatic t_auto_off();
    longint sum[4]; bit seen;
    set_en(1'b0);
    avg_log2 = 4'd4;
    @(negedge clk); start_off = 1'b1;
    @(negedge clk); start_off = 1'b0;
    chk("R8 busy during auto-offset", longint'(busy), 1);
    cfg_wr(4'b0110, 'h30000);
    for (int s = 0; s < 4; s++) begin
      sum[s] = 0;
      for (int i = 0; i < 16; i++) begin
        feed(1000 * (s + 1) + 3 * i, s);
        sum[s] += 1000 * (s + 1) + 3 * i;
      end
      if (s == 0) for (int i = 0; i < 4; i++) feed(900000, 0);
    end
    feed_end();
    wait_done(20, seen);
    chk("R8 done pulse after auto-offset", longint'(seen), 1);
    @(negedge clk);
    chk("R8 done one cycle", longint'(done), 0);
    chk("R8 busy released", longint'(busy), 0);
    for (int s = 0; s < 4; s++) m_off[s] = sum[s] >>> 4;
    m_en = 1'b1;
    for (int s = 0; s < 4; s++) probe("R6 averaged offset", 50000, s);
    probe("R8 write while busy ignored", 200000, 2);
  endtask

  // R7: auto-gain with clamped count
  task automatic t_auto_gain();
    longint sum[4]; longint base[4]; bit seen; longint q;
    base[0] = 800000; base[1] = 760000; base[2] = 500000; base[3] = 530000;
    set_coef(0, 1, 'h10000);
    set_coef(2, 1, 'h14000);
    avg_log2 = 4'd2;
    @(negedge clk); start_gain = 1'b1;
    @(negedge clk); start_gain = 1'b0;
    for (int s = 0; s < 4; s++) begin
      sum[s] = 0;
      for (int i = 0; i < 20; i++) begin
        feed(i < 16 ? base[s] + 7 * i : base[s] + 50000, s);
        if (i < 16) sum[s] += base[s] + 7 * i - m_off[s];
      end
    end
    feed_end();
    wait_done(400, seen);
    chk("R7 done after auto-gain", longint'(seen), 1);
    for (int c = 0; c < 2; c++) begin
      q = (m_gain[2 * c] * sum[2 * c]) / sum[2 * c + 1];
      if (q > 262143) q = 262143;
      m_gain[2 * c + 1] = q;
    end
    probe("R7 B gain ch1", 700000, 1);
    probe("R7 B gain ch2", 700000, 3);
    probe("R7 A gain unchanged ch1", 700000, 0);
    probe("R7 A gain unchanged ch2", 700000, 2);
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin m_off[s] = 0; m_gain[s] = 'h10000; end
    m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formula();
    t_bypass();
    t_auto_off();
    t_auto_gain();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule